// File: doc/BRIEF.md
# Self-Extending Prototype Learning Controller

This block grows a nearest-match classifier's set of stored prototypes while the classifier is running. It watches every classification result. A result can be a miss, where no neuron claimed the input. When a miss arrives together with a learn request and the controller is waiting, it captures the presented vector, the requested category and the current maximum influence radius. It then finds the lowest-numbered cell that holds no prototype yet and writes all three into that cell. The write goes through the configuration write port, in one single write. After the write, the controller marks the cell as occupied.

The controller keeps the occupancy bitmap and a count of occupied cells, and raises a full flag when no cell is left. It also keeps one saturating win counter per cell, which grows each time that cell wins a classification. Any one of these counters can be read through an index input, and a single strobe clears all of them. Distance computation, winner selection and the prototype storage itself belong to neighbouring blocks.

Top module: `learn_commit_ctrl`

## Requirements
- R1: A learn sequence starts only on a clock edge where `res_valid`=1, `res_hit`=0 and `learn_req`=1 while the controller is waiting and `full`=0. A hit, or a miss without a learn request, produces no configuration write and leaves `commit_cnt` unchanged.
- R2: The configuration write targets the lowest-index cell whose bit in `commit_mask` is 0 (bit i of `commit_mask` belongs to cell i).
- R3: `cfg_we` is 1 for exactly one cycle, in the second cycle after the starting edge. During that cycle `cfg_vec`, `cfg_cat` and `cfg_inf` carry the `vec_in`, `learn_cat` and `max_inf` values sampled at the starting edge, even if those inputs have changed since.
- R4: One cycle after the write cycle, the written cell's bit in `commit_mask` becomes 1 and `commit_cnt` grows by exactly one. `commit_cnt` always equals the number of 1 bits in `commit_mask`.
- R5: Learn requests that arrive while a sequence is in progress, in the three cycles after a starting edge, are ignored: there is no second write and no extra count.
- R6: `full` is 1 exactly when every cell is occupied. While `full` is 1, no configuration write occurs and learn requests are ignored.
- R7: On each edge with `res_valid`=1 and `res_hit`=1, the win counter of cell `res_winner` increases by one. `rd_count` shows the counter of cell `rd_idx`.
- R8: A win counter that holds its all-ones value stays there on further wins.
- R9: `cnt_clr`=1 on an edge sets every win counter to 0. It takes priority over a win on the same edge.
- R10: After a synchronous active-low reset: `commit_mask`=0, `commit_cnt`=0, `full`=0, `cfg_we`=0, and every win counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_valid | input | 1 | A classification result is presented this cycle |
| res_hit | input | 1 | At least one neuron recognised the input |
| res_winner | input | IDX_W | Index of the winning neuron when `res_hit`=1 |
| learn_req | input | 1 | Request to learn the current input if it missed |
| learn_cat | input | CAT_W | Category for the new prototype |
| vec_in | input | DIM*COMP_W | Input vector of the current result |
| max_inf | input | INF_W | Initial influence radius for new prototypes |
| cnt_clr | input | 1 | Clears all win counters |
| rd_idx | input | IDX_W | Cell whose win counter is shown on `rd_count` |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_addr | output | IDX_W | Target cell of the write |
| cfg_vec | output | DIM*COMP_W | Prototype vector to store |
| cfg_cat | output | CAT_W | Category to store |
| cfg_inf | output | INF_W | Influence radius to store |
| commit_mask | output | NUM_CELLS | Occupancy bit per cell |
| commit_cnt | output | CNT_W | Number of occupied cells |
| full | output | 1 | No free cell remains |
| rd_count | output | WIN_W | Win counter of cell `rd_idx` |

## Verification
Results are offered in four patterns: a hit with a learn request, a miss without one, a miss with one, and a miss with one arriving while a sequence runs. The first two show that both the miss and the request are needed. The third shows the write timing, the data capture and the lowest-free placement. The fourth shows that requests during a sequence are ignored. Filling the array tells the last free cell apart from the full state. Win streams on two cells tell a counter step apart from saturation, and a clear on the same edge as a win shows which one has priority.

// File: rtl/learn_pkg.sv
// Package: shared types for the prototype learning controller.
// Assumes: nothing beyond IEEE 1800-2017.
package learn_pkg;

    // Sequencer phases, in the order they are visited.
    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_FIND   = 2'd1,
        LS_WRITE  = 2'd2,
        LS_COMMIT = 2'd3
    } learn_state_t;

endpackage

// File: rtl/lowest_free_finder.sv
// Module: lowest_free_finder
// Finds the lowest-index cell whose occupied bit is clear.
// Assumes: NUM_CELLS >= 2; free_idx is meaningless when none_free is 1.
module lowest_free_finder #(
    parameter int NUM_CELLS = 16,
    localparam int IDX_W = $clog2(NUM_CELLS)
) (
    input  logic [NUM_CELLS-1:0] used_mask,
    output logic [IDX_W-1:0]     free_idx,
    output logic                 none_free
);

    // Priority scan: the last assignment wins, so scan from the top down.
    always_comb begin
        free_idx = '0;
        for (int i = NUM_CELLS - 1; i >= 0; i--) begin
            if (!used_mask[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    // No free cell when every bit is set.
    always_comb begin
        none_free = &used_mask;
    end

endmodule

// File: rtl/commit_tracker.sv
// Module: commit_tracker
// Holds the occupancy bitmap and the number of occupied cells.
// Assumes: commit_pulse only names a currently free cell.
module commit_tracker #(
    parameter int NUM_CELLS = 16,
    localparam int IDX_W = $clog2(NUM_CELLS),
    localparam int CNT_W = $clog2(NUM_CELLS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_pulse,
    input  logic [IDX_W-1:0]     commit_idx,
    output logic [NUM_CELLS-1:0] used_mask,
    output logic [CNT_W-1:0]     used_cnt,
    output logic                 is_full
);

    localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(NUM_CELLS);

    // Mark the committed cell and count it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_mask <= '0;
            used_cnt  <= '0;
        end else if (commit_pulse) begin
            used_mask[commit_idx] <= 1'b1;
            used_cnt              <= used_cnt + 1'b1;
        end
    end

    // Full when the count reaches the cell total.
    always_comb begin
        is_full = (used_cnt == FULL_VAL);
    end

endmodule

// File: rtl/win_counter_bank.sv
// Module: win_counter_bank
// One saturating win counter per cell, with a read port and a clear strobe.
// Assumes: clear has priority over a simultaneous win.
module win_counter_bank #(
    parameter int NUM_CELLS = 16,
    parameter int WIN_W = 16,
    localparam int IDX_W = $clog2(NUM_CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIN_W-1:0] rd_count
);

    logic [WIN_W-1:0] cnt_q [NUM_CELLS];

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        logic bump;

        // This cell won and its counter has headroom.
        always_comb begin
            bump = win_valid && (win_idx == IDX_W'(g)) && !(&cnt_q[g]);
        end

        // Per-cell counter: reset/clear first, then saturating increment.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                cnt_q[g] <= '0;
            end else if (bump) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end
    end

    // Read multiplexer, guarded against indices past the last cell.
    always_comb begin
        rd_count = '0;
        if (int'(rd_idx) < NUM_CELLS) begin
            rd_count = cnt_q[rd_idx];
        end
    end

endmodule

// File: rtl/learn_sequencer.sv
// Module: learn_sequencer
// Runs the IDLE -> FIND -> WRITE -> COMMIT sequence that stores one prototype.
// Assumes: free_idx/none_free describe the current occupancy; new requests
// are only accepted in IDLE.
module learn_sequencer #(
    parameter int NUM_CELLS = 16,
    parameter int VEC_W = 32,
    parameter int CAT_W = 8,
    parameter int INF_W = 12,
    localparam int IDX_W = $clog2(NUM_CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic             res_hit,
    input  logic             learn_req,
    input  logic [CAT_W-1:0] learn_cat,
    input  logic [VEC_W-1:0] vec_in,
    input  logic [INF_W-1:0] max_inf,
    input  logic             is_full,
    input  logic [IDX_W-1:0] free_idx,
    input  logic             none_free,
    output logic             cfg_we,
    output logic [IDX_W-1:0] cfg_addr,
    output logic [VEC_W-1:0] cfg_vec,
    output logic [CAT_W-1:0] cfg_cat,
    output logic [INF_W-1:0] cfg_inf,
    output logic             commit_pulse
);

    import learn_pkg::*;

    learn_state_t     state_q;
    logic             start;
    logic [IDX_W-1:0] slot_q;
    logic [VEC_W-1:0] vec_q;
    logic [CAT_W-1:0] cat_q;
    logic [INF_W-1:0] inf_q;

    // Accept a miss with a learn request only when waiting and not full.
    always_comb begin
        start = (state_q == LS_IDLE) && res_valid && !res_hit && learn_req && !is_full;
    end

    // Phase register and capture of the data to be stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            slot_q  <= '0;
            vec_q   <= '0;
            cat_q   <= '0;
            inf_q   <= '0;
        end else begin
            case (state_q)
                LS_IDLE: begin
                    if (start) begin
                        vec_q   <= vec_in;
                        cat_q   <= learn_cat;
                        inf_q   <= max_inf;
                        state_q <= LS_FIND;
                    end
                end
                LS_FIND: begin
                    slot_q  <= free_idx;
                    state_q <= none_free ? LS_IDLE : LS_WRITE;
                end
                LS_WRITE:  state_q <= LS_COMMIT;
                default:   state_q <= LS_IDLE;
            endcase
        end
    end

    // Configuration port and commit strobe decoded from the phase.
    always_comb begin
        cfg_we       = (state_q == LS_WRITE);
        commit_pulse = (state_q == LS_COMMIT);
        cfg_addr     = slot_q;
        cfg_vec      = vec_q;
        cfg_cat      = cat_q;
        cfg_inf      = inf_q;
    end

endmodule

// File: rtl/learn_commit_ctrl.sv
// Module: learn_commit_ctrl (top)
// Adds prototypes to the first free cell on a recognition miss with a learn
// request, tracks occupancy and keeps per-cell win counters.
// Assumes: NUM_CELLS >= 2; res_winner is meaningful only with res_hit.
module learn_commit_ctrl #(
    parameter int NUM_CELLS = 16,
    parameter int DIM = 4,
    parameter int COMP_W = 8,
    parameter int CAT_W = 8,
    parameter int INF_W = 12,
    parameter int WIN_W = 16,
    localparam int IDX_W = $clog2(NUM_CELLS),
    localparam int CNT_W = $clog2(NUM_CELLS + 1),
    localparam int VEC_W = DIM * COMP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_valid,
    input  logic                 res_hit,
    input  logic [IDX_W-1:0]     res_winner,
    input  logic                 learn_req,
    input  logic [CAT_W-1:0]     learn_cat,
    input  logic [VEC_W-1:0]     vec_in,
    input  logic [INF_W-1:0]     max_inf,
    input  logic                 cnt_clr,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 cfg_we,
    output logic [IDX_W-1:0]     cfg_addr,
    output logic [VEC_W-1:0]     cfg_vec,
    output logic [CAT_W-1:0]     cfg_cat,
    output logic [INF_W-1:0]     cfg_inf,
    output logic [NUM_CELLS-1:0] commit_mask,
    output logic [CNT_W-1:0]     commit_cnt,
    output logic                 full,
    output logic [WIN_W-1:0]     rd_count
);

    logic [IDX_W-1:0] free_idx;
    logic             none_free;
    logic             commit_pulse;

    lowest_free_finder #(.NUM_CELLS(NUM_CELLS)) u_find (
        .used_mask (commit_mask),
        .free_idx  (free_idx),
        .none_free (none_free)
    );

    learn_sequencer #(
        .NUM_CELLS (NUM_CELLS),
        .VEC_W     (VEC_W),
        .CAT_W     (CAT_W),
        .INF_W     (INF_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .res_hit      (res_hit),
        .learn_req    (learn_req),
        .learn_cat    (learn_cat),
        .vec_in       (vec_in),
        .max_inf      (max_inf),
        .is_full      (full),
        .free_idx     (free_idx),
        .none_free    (none_free),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_vec      (cfg_vec),
        .cfg_cat      (cfg_cat),
        .cfg_inf      (cfg_inf),
        .commit_pulse (commit_pulse)
    );

    commit_tracker #(.NUM_CELLS(NUM_CELLS)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_pulse (commit_pulse),
        .commit_idx   (cfg_addr),
        .used_mask    (commit_mask),
        .used_cnt     (commit_cnt),
        .is_full      (full)
    );

    win_counter_bank #(
        .NUM_CELLS (NUM_CELLS),
        .WIN_W     (WIN_W)
    ) u_wins (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .win_valid (res_valid && res_hit),
        .win_idx   (res_winner),
        .rd_idx    (rd_idx),
        .rd_count  (rd_count)
    );

endmodule

// File: rtl/learn_commit_ctrl_chk.sv
// Module: learn_commit_ctrl_chk
// Port-level properties of the learning controller, bound to the top.
// Assumes: the same parameter values as the bound instance.
module learn_commit_ctrl_chk #(
    parameter int NUM_CELLS = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5,
    parameter int WIN_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_clr,
    input logic [IDX_W-1:0]     rd_idx,
    input logic                 cfg_we,
    input logic [IDX_W-1:0]     cfg_addr,
    input logic [NUM_CELLS-1:0] commit_mask,
    input logic [CNT_W-1:0]     commit_cnt,
    input logic                 full,
    input logic [WIN_W-1:0]     rd_count
);

    logic                 armed;
    logic [NUM_CELLS-1:0] below;

    // Becomes 1 one edge after reset is released, so $past sees defined values.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Cells below the write address.
    always_comb begin
        below = (NUM_CELLS'(1) << cfg_addr) - NUM_CELLS'(1);
    end

    assert_write_lowest_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (!commit_mask[cfg_addr] && ((commit_mask & below) == below)));

    assert_single_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cfg_we);

    assert_count_matches_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(commit_cnt) == $countones(commit_mask));

    assert_count_steps_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && commit_cnt != $past(commit_cnt)) |-> commit_cnt == $past(commit_cnt) + 1'b1);

    assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !cfg_we);

    assert_full_all_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full == (&commit_mask));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(cnt_clr) && $stable(rd_idx)) |-> rd_count >= $past(rd_count));

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> rd_count == '0);

endmodule

bind learn_commit_ctrl learn_commit_ctrl_chk #(
    .NUM_CELLS (NUM_CELLS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W),
    .WIN_W     (WIN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_clr     (cnt_clr),
    .rd_idx      (rd_idx),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .commit_mask (commit_mask),
    .commit_cnt  (commit_cnt),
    .full        (full),
    .rd_count    (rd_count)
);

// File: tb/sim_learn_commit_ctrl.sv
// Directed bench for learn_commit_ctrl: one task per scenario.
module sim_learn_commit_ctrl;

    localparam int N      = 4;
    localparam int DIM    = 2;
    localparam int COMP_W = 8;
    localparam int CAT_W  = 4;
    localparam int INF_W  = 10;
    localparam int WIN_W  = 3;
    localparam int IDX_W  = $clog2(N);
    localparam int CNT_W  = $clog2(N + 1);
    localparam int VEC_W  = DIM * COMP_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             res_valid = 1'b0;
    logic             res_hit = 1'b0;
    logic [IDX_W-1:0] res_winner = '0;
    logic             learn_req = 1'b0;
    logic [CAT_W-1:0] learn_cat = '0;
    logic [VEC_W-1:0] vec_in = '0;
    logic [INF_W-1:0] max_inf = '0;
    logic             cnt_clr = 1'b0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic             cfg_we;
    logic [IDX_W-1:0] cfg_addr;
    logic [VEC_W-1:0] cfg_vec;
    logic [CAT_W-1:0] cfg_cat;
    logic [INF_W-1:0] cfg_inf;
    logic [N-1:0]     commit_mask;
    logic [CNT_W-1:0] commit_cnt;
    logic             full;
    logic [WIN_W-1:0] rd_count;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    learn_commit_ctrl #(
        .NUM_CELLS(N), .DIM(DIM), .COMP_W(COMP_W),
        .CAT_W(CAT_W), .INF_W(INF_W), .WIN_W(WIN_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_hit(res_hit),
        .res_winner(res_winner), .learn_req(learn_req), .learn_cat(learn_cat),
        .vec_in(vec_in), .max_inf(max_inf), .cnt_clr(cnt_clr), .rd_idx(rd_idx),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_vec(cfg_vec), .cfg_cat(cfg_cat),
        .cfg_inf(cfg_inf), .commit_mask(commit_mask), .commit_cnt(commit_cnt),
        .full(full), .rd_count(rd_count)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one result for one edge, then return to quiet inputs.
    task automatic drive_result(input logic hit, input logic learn, input logic [IDX_W-1:0] win,
                                input logic [CAT_W-1:0] cat, input logic [VEC_W-1:0] vec,
                                input logic [INF_W-1:0] inf);
        @(negedge clk);
        res_valid = 1'b1; res_hit = hit; learn_req = learn; res_winner = win;
        learn_cat = cat; vec_in = vec; max_inf = inf;
        @(negedge clk);
        res_valid = 1'b0; res_hit = 1'b0; learn_req = 1'b0; res_winner = '0;
        learn_cat = '1; vec_in = '1; max_inf = '1;
    endtask

    task automatic t_reset();
        check("R10 mask", commit_mask, 0);
        check("R10 count", commit_cnt, 0);
        check("R10 full", full, 0);
        check("R10 cfg_we", cfg_we, 0);
        rd_idx = 0; #1;
        check("R10 win counter", rd_count, 0);
    endtask

    // A result that must not start a sequence: watch four cycles.
    task automatic t_no_learn(input logic hit, input string req);
        int writes;
        writes = 0;
        drive_result(hit, !hit ? 1'b0 : 1'b1, 0, 4'h3, 16'h1234, 10'h55);
        for (int i = 0; i < 4; i++) begin
            writes += int'(cfg_we);
            @(negedge clk);
        end
        check(req, writes, 0);
        check(req, commit_cnt, exp_cnt);
    endtask

    // Full learn sequence with cycle-exact checks.
    task automatic t_learn(input int exp_addr, input logic [CAT_W-1:0] cat,
                           input logic [VEC_W-1:0] vec, input logic [INF_W-1:0] inf);
        drive_result(1'b0, 1'b1, 0, cat, vec, inf);
        check("R3 no write in first cycle", cfg_we, 0);
        @(negedge clk);
        check("R3 write strobe", cfg_we, 1);
        check("R2 write address lowest free", cfg_addr, exp_addr);
        check("R3 captured vector", cfg_vec, vec);
        check("R3 captured category", cfg_cat, cat);
        check("R3 captured influence", cfg_inf, inf);
        check("R4 mask not yet set", commit_mask[exp_addr], 0);
        @(negedge clk);
        check("R3 write one cycle", cfg_we, 0);
        @(negedge clk);
        exp_cnt++;
        check("R4 mask bit set", commit_mask[exp_addr], 1);
        check("R4 count step", commit_cnt, exp_cnt);
    endtask

    // Second request while a sequence runs must be dropped.
    task automatic t_busy_ignore();
        int writes;
        writes = 0;
        @(negedge clk);
        res_valid = 1'b1; res_hit = 1'b0; learn_req = 1'b1; learn_cat = 4'h9; vec_in = 16'hAAAA; max_inf = 10'h11;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            learn_cat = 4'h6; vec_in = 16'h5555;
            writes += int'(cfg_we);
            if (cfg_we) check("R5 first request data kept", cfg_cat, 4'h9);
        end
        res_valid = 1'b0; learn_req = 1'b0;
        for (int i = 0; i < 5; i++) begin
            writes += int'(cfg_we);
            @(negedge clk);
        end
        exp_cnt++;
        check("R5 single write", writes, 1);
        check("R5 single count", commit_cnt, exp_cnt);
    endtask

    task automatic t_full();
        int writes;
        writes = 0;
        check("R6 full flag", full, 1);
        drive_result(1'b0, 1'b1, 0, 4'h2, 16'hBEEF, 10'h3);
        for (int i = 0; i < 4; i++) begin
            writes += int'(cfg_we);
            @(negedge clk);
        end
        check("R6 no write when full", writes, 0);
        check("R6 count stays", commit_cnt, N);
    endtask

    task automatic t_counters();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        rd_idx = 2; #1;
        check("R9 cleared", rd_count, 0);
        for (int i = 0; i < 3; i++) drive_result(1'b1, 1'b0, 2, 0, 0, 0);
        rd_idx = 2; #1;
        check("R7 wins on cell 2", rd_count, 3);
        rd_idx = 1; #1;
        check("R7 other cell untouched", rd_count, 0);
        for (int i = 0; i < 10; i++) drive_result(1'b1, 1'b0, 1, 0, 0, 0);
        rd_idx = 1; #1;
        check("R8 saturated", rd_count, 7);
        @(negedge clk);
        res_valid = 1'b1; res_hit = 1'b1; res_winner = 1; cnt_clr = 1'b1;
        @(negedge clk);
        res_valid = 1'b0; res_hit = 1'b0; cnt_clr = 1'b0;
        rd_idx = 1; #1;
        check("R9 clear beats win", rd_count, 0);
        rd_idx = 2; #1;
        check("R9 all cleared", rd_count, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_learn(1'b1, "R1 hit with learn ignored");
        t_no_learn(1'b0, "R1 miss without learn ignored");
        t_learn(0, 4'h5, 16'hC0DE, 10'h2A5);
        t_busy_ignore();
        t_learn(2, 4'hA, 16'h0F0F, 10'h100);
        t_learn(3, 4'h1, 16'h7E81, 10'h3FF);
        t_full();
        t_counters();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule